// File: doc/BRIEF.md
# Address-Space Tagged Translation Cache

This block is a fully associative translation cache for 4 KB pages. Every line holds a 20-bit virtual page number, a 7-bit address-space tag, a physical frame number and three permission bits. A requester presents an address-space tag and a 32-bit virtual address. One cycle later the block answers with hit or miss and, on a hit, the frame and permissions of the matching line.

On a miss the block records the missing page and its address-space tag. An external table walker reads them and answers with a refill, which the block writes into a line picked by its replacement logic. A 32-bit invalidation word removes lines in one cycle. It can remove every line, the lines of one address space, one 4 MB section or one 16 KB group, each optionally restricted to a single address space. A configuration word sets how many lines are in use, whether hits may be served while a miss is outstanding, and whether replacement is round-robin.

Top module: `tlbx_core`

## Requirements
- R1: After reset no line is valid, `lk_rsp_valid` and `miss_pend` are low and `lk_ready` is high. The configuration resets to all lines in use, hit-under-miss off and round-robin off.
- R2: A lookup is accepted when `lk_valid` and `lk_ready` are both high. In the next cycle, and only then, `lk_rsp_valid` is high. `lk_hit` is high when a valid line in use has the same address-space tag and the same `lk_va[31:12]`. On a hit, `lk_pfn` and `lk_perm` return that line's stored values.
- R3: An accepted lookup that misses while no miss is pending sets `miss_pend` and captures its tag in `miss_asid` and its page in `miss_vpn`.
- R4: Configuration bit 29 enables hit-under-miss. When it is off, `lk_ready` is low while a miss is pending. When it is on, lookups are still accepted and answered, and further misses leave the captured miss unchanged.
- R5: A refill (`rf_valid`) clears `miss_pend` and writes its tag, page, frame and permissions into a line. If a valid line in use already has the same tag and page, that line is updated in place.
- R6: An invalidation takes effect in the cycle after `fl_valid`. Command bits [1:0] select the kind: 0 matches every page, 2 matches the section whose `va[31:22]` sits in command bits [19:10], 3 matches the group whose `va[31:14]` sits in command bits [19:2], and 1 matches nothing. When bit 31 is set, only lines whose tag equals command bits [30:24] are removed.
- R7: When an invalidation and a refill arrive in the same cycle, the invalidation is applied. The refill is discarded if its own tag and page match the invalidation; otherwise it is written.
- R8: With round-robin off, a new refill goes to the lowest-numbered invalid line in use, or to line 0 when every line in use is valid.
- R9: Configuration bit 28 enables round-robin. A pointer starting at line 0 then picks the line for each new refill and steps cyclically through the lines in use.
- R10: Configuration bits [3:0] (with the default of 8 lines) give the number of lines in use; 0 or a value above the line count means all lines. Lines outside that range never hit and are never chosen for a refill, but they keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: bit 29 hit-under-miss, bit 28 round-robin, low bits line count |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | The block can accept a lookup |
| lk_asid | input | 7 | Address-space tag of the lookup |
| lk_va | input | 32 | Virtual address of the lookup |
| lk_rsp_valid | output | 1 | Lookup answer is valid |
| lk_hit | output | 1 | Lookup found a line |
| lk_pfn | output | PFN_W | Physical frame number of the hit |
| lk_perm | output | 3 | Permission bits of the hit |
| miss_pend | output | 1 | A miss is waiting for a refill |
| miss_asid | output | 7 | Tag of the pending miss |
| miss_vpn | output | 20 | Virtual page of the pending miss |
| rf_valid | input | 1 | Refill strobe from the table walker |
| rf_asid | input | 7 | Refill tag |
| rf_vpn | input | 20 | Refill virtual page |
| rf_pfn | input | PFN_W | Refill frame number |
| rf_perm | input | 3 | Refill permission bits |
| fl_valid | input | 1 | Invalidation strobe |
| fl_cmd | input | 32 | Invalidation command word |

## Verification
The lookup path is tried with pages that share a page number but differ in tag, pages that differ in one page bit under the same tag, and addresses with arbitrary low offset bits. This separates tag matching from page matching and shows the offset is ignored. Each invalidation kind is aimed at a pair of lines that differ in only one of tag, group or section, so a too-wide or too-narrow match removes the wrong line. Replacement is tested with a small line count, so round-robin wrap, fallback to line 0, in-place update and out-of-range lines each evict a different line that lookups can observe.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
   localparam int ASID_W = 7;
   localparam int VPN_W  = 20;
   localparam int PERM_W = 3;

   typedef enum logic [1:0] {
      FLK_ALL  = 2'd0,
      FLK_NONE = 2'd1,
      FLK_SECT = 2'd2,
      FLK_GRP  = 2'd3
   } flk_e;

   typedef struct packed {
      logic              en;
      logic              use_asid;
      logic [ASID_W-1:0] asid;
      logic [VPN_W-1:0]  vmask;
      logic [VPN_W-1:0]  vval;
   } fl_dec_t;

   function automatic logic fl_hit(fl_dec_t d, logic [ASID_W-1:0] a, logic [VPN_W-1:0] v);
      return d.en && (!d.use_asid || (d.asid == a)) && ((v & d.vmask) == d.vval);
   endfunction
endpackage

// File: rtl/tlbx_flush_dec.sv
module tlbx_flush_dec
   import tlbx_pkg::*;
(
   input  logic [31:0] cmd,
   output fl_dec_t     dec
);
   flk_e kind;
   logic unused_cmd;

   assign kind       = flk_e'(cmd[1:0]);
   assign unused_cmd = ^cmd[23:20];

   always_comb begin
      dec.use_asid = cmd[31];
      dec.asid     = cmd[30:24];
      case (kind)
         FLK_ALL:  begin dec.en = 1'b1; dec.vmask = '0; end
         FLK_SECT: begin dec.en = 1'b1; dec.vmask = {{10{1'b1}}, {10{1'b0}}}; end
         FLK_GRP:  begin dec.en = 1'b1; dec.vmask = {{18{1'b1}}, 2'b00}; end
         default:  begin dec.en = 1'b0; dec.vmask = '0; end
      endcase
      dec.vval = cmd[19:0] & dec.vmask;
   end
endmodule

// File: rtl/tlbx_entries.sv
module tlbx_entries
   import tlbx_pkg::*;
#(
   parameter int N     = 8,
   parameter int PFN_W = 20,
   localparam int IDX_W = $clog2(N)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N-1:0]                act,
   input  logic [ASID_W-1:0]           lk_asid,
   input  logic [VPN_W-1:0]            lk_vpn,
   input  logic [ASID_W-1:0]           rf_asid,
   input  logic [VPN_W-1:0]            rf_vpn,
   input  logic [PFN_W-1:0]            rf_pfn,
   input  logic [PERM_W-1:0]           rf_perm,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic                        fl_valid,
   input  fl_dec_t                     fl_d,
   output logic [N-1:0]                valid_vec,
   output logic [N-1:0]                hit_vec,
   output logic [N-1:0]                upd_vec,
   output logic [N-1:0][PFN_W-1:0]     pfn_arr,
   output logic [N-1:0][PERM_W-1:0]    perm_arr
);
   for (genvar g = 0; g < N; g++) begin : g_line
      logic              vld_q;
      logic [ASID_W-1:0] asid_q;
      logic [VPN_W-1:0]  vpn_q;
      logic [PFN_W-1:0]  pfn_q;
      logic [PERM_W-1:0] perm_q;
      logic              kill;
      logic              sel;

      assign kill = fl_valid && fl_hit(fl_d, asid_q, vpn_q);
      assign sel  = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            asid_q <= '0;
            vpn_q  <= '0;
            pfn_q  <= '0;
            perm_q <= '0;
         end else if (sel) begin
            vld_q  <= 1'b1;
            asid_q <= rf_asid;
            vpn_q  <= rf_vpn;
            pfn_q  <= rf_pfn;
            perm_q <= rf_perm;
         end else if (kill) begin
            vld_q  <= 1'b0;
         end
      end

      assign valid_vec[g] = vld_q;
      assign hit_vec[g]   = vld_q && act[g] && (asid_q == lk_asid) && (vpn_q == lk_vpn);
      assign upd_vec[g]   = vld_q && act[g] && (asid_q == rf_asid) && (vpn_q == rf_vpn);
      assign pfn_arr[g]   = pfn_q;
      assign perm_arr[g]  = perm_q;
   end
endmodule

// File: rtl/tlbx_victim.sv
module tlbx_victim #(
   parameter int N = 8,
   localparam int IDX_W  = $clog2(N),
   localparam int LCNT_W = $clog2(N + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rr_en,
   input  logic [LCNT_W-1:0] lines,
   input  logic [N-1:0]      act,
   input  logic [N-1:0]      valid_vec,
   input  logic [N-1:0]      upd_vec,
   input  logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx
);
   logic [LCNT_W-1:0] ptr_q, ptr_ok, ptr_inc;
   logic [IDX_W-1:0]  upd_idx, free_idx;
   logic              upd_any, free_any;

   always_comb begin
      upd_idx  = '0;
      free_idx = '0;
      free_any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (upd_vec[i]) upd_idx = IDX_W'(i);
         if (act[i] && !valid_vec[i]) begin
            free_idx = IDX_W'(i);
            free_any = 1'b1;
         end
      end
   end

   assign upd_any = |upd_vec;
   assign ptr_ok  = (ptr_q < lines) ? ptr_q : '0;
   assign ptr_inc = ptr_ok + LCNT_W'(1);

   always_comb begin
      if (upd_any)       wr_idx = upd_idx;
      else if (rr_en)    wr_idx = ptr_ok[IDX_W-1:0];
      else if (free_any) wr_idx = free_idx;
      else               wr_idx = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (wr_en && !upd_any && rr_en)
         ptr_q <= (ptr_inc >= lines) ? '0 : ptr_inc;
   end
endmodule

// File: rtl/tlbx_core.sv
module tlbx_core
   import tlbx_pkg::*;
#(
   parameter int N     = 8,
   parameter int PFN_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [31:0]       cfg_wdata,
   input  logic              lk_valid,
   output logic              lk_ready,
   input  logic [6:0]        lk_asid,
   input  logic [31:0]       lk_va,
   output logic              lk_rsp_valid,
   output logic              lk_hit,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic [2:0]        lk_perm,
   output logic              miss_pend,
   output logic [6:0]        miss_asid,
   output logic [19:0]       miss_vpn,
   input  logic              rf_valid,
   input  logic [6:0]        rf_asid,
   input  logic [19:0]       rf_vpn,
   input  logic [PFN_W-1:0]  rf_pfn,
   input  logic [2:0]        rf_perm,
   input  logic              fl_valid,
   input  logic [31:0]       fl_cmd
);
   localparam int IDX_W  = $clog2(N);
   localparam int LCNT_W = $clog2(N + 1);

   if (N < 2 || N > 64) begin : g_bad_n
      $error("tlbx_core: N must lie in 2..64");
   end
   if (PFN_W < 1 || PFN_W > 32) begin : g_bad_pfn
      $error("tlbx_core: PFN_W must lie in 1..32");
   end
   if (LCNT_W > 27) begin : g_bad_lcnt
      $error("tlbx_core: line count field overlaps option bits");
   end

   logic              cfg_hum_q, cfg_rr_q;
   logic [LCNT_W-1:0] cfg_lines_q, lines_eff;
   logic [N-1:0]      act, valid_vec, hit_vec, upd_vec;
   logic [N-1:0][PFN_W-1:0]  pfn_arr;
   logic [N-1:0][PERM_W-1:0] perm_arr;
   logic [PFN_W-1:0]  pfn_mux;
   logic [PERM_W-1:0] perm_mux;
   logic [IDX_W-1:0]  wr_idx;
   fl_dec_t           fl_d;
   logic              lk_fire, miss_fire, rf_drop, wr_en;
   logic [VPN_W-1:0]  lk_vpn;
   logic              unused_in;

   assign lk_vpn    = lk_va[31:12];
   assign unused_in = ^{lk_va[11:0], cfg_wdata[31:30], cfg_wdata[27:LCNT_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_hum_q   <= 1'b0;
         cfg_rr_q    <= 1'b0;
         cfg_lines_q <= '0;
      end else if (cfg_we) begin
         cfg_hum_q   <= cfg_wdata[29];
         cfg_rr_q    <= cfg_wdata[28];
         cfg_lines_q <= cfg_wdata[LCNT_W-1:0];
      end
   end

   assign lines_eff = (cfg_lines_q == '0 || cfg_lines_q > LCNT_W'(N)) ? LCNT_W'(N) : cfg_lines_q;

   for (genvar g = 0; g < N; g++) begin : g_act
      assign act[g] = (LCNT_W'(g) < lines_eff);
   end

   tlbx_flush_dec u_fdec (.cmd(fl_cmd), .dec(fl_d));

   assign rf_drop = fl_valid && fl_hit(fl_d, rf_asid, rf_vpn);
   assign wr_en   = rf_valid && !rf_drop;

   tlbx_entries #(.N(N), .PFN_W(PFN_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .act(act),
      .lk_asid(lk_asid), .lk_vpn(lk_vpn),
      .rf_asid(rf_asid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_perm(rf_perm),
      .wr_en(wr_en), .wr_idx(wr_idx),
      .fl_valid(fl_valid), .fl_d(fl_d),
      .valid_vec(valid_vec), .hit_vec(hit_vec), .upd_vec(upd_vec),
      .pfn_arr(pfn_arr), .perm_arr(perm_arr)
   );

   tlbx_victim #(.N(N)) u_vic (
      .clk(clk), .rst_n(rst_n), .rr_en(cfg_rr_q), .lines(lines_eff),
      .act(act), .valid_vec(valid_vec), .upd_vec(upd_vec),
      .wr_en(wr_en), .wr_idx(wr_idx)
   );

   always_comb begin
      pfn_mux  = '0;
      perm_mux = '0;
      for (int i = 0; i < N; i++) begin
         if (hit_vec[i]) begin
            pfn_mux  = pfn_mux | pfn_arr[i];
            perm_mux = perm_mux | perm_arr[i];
         end
      end
   end

   assign lk_ready  = !miss_pend || cfg_hum_q;
   assign lk_fire   = lk_valid && lk_ready;
   assign miss_fire = lk_fire && !(|hit_vec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_rsp_valid <= 1'b0;
         lk_hit       <= 1'b0;
         lk_pfn       <= '0;
         lk_perm      <= '0;
      end else begin
         lk_rsp_valid <= lk_fire;
         lk_hit       <= lk_fire && (|hit_vec);
         lk_pfn       <= pfn_mux;
         lk_perm      <= perm_mux;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miss_pend <= 1'b0;
         miss_asid <= '0;
         miss_vpn  <= '0;
      end else if (miss_pend) begin
         if (rf_valid) miss_pend <= 1'b0;
      end else if (miss_fire) begin
         miss_pend <= 1'b1;
         miss_asid <= lk_asid;
         miss_vpn  <= lk_vpn;
      end
   end
endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk #(
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         lk_valid,
   input logic         lk_ready,
   input logic         lk_rsp_valid,
   input logic         lk_hit,
   input logic         miss_pend,
   input logic [6:0]   miss_asid,
   input logic [19:0]  miss_vpn,
   input logic         rf_valid,
   input logic         fl_valid,
   input logic [31:0]  fl_cmd,
   input logic         cfg_hum,
   input logic [N-1:0] hit_vec,
   input logic [N-1:0] valid_vec
);
   AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_ready) |=> lk_rsp_valid); // R2
   AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_valid && lk_ready) |=> !lk_rsp_valid); // R2
   AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_rsp_valid); // R2
   AST_BLOCK_NO_HUM: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_pend && !cfg_hum) |-> !lk_ready); // R4
   AST_MISS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_pend && !rf_valid) |=> (miss_pend && $stable(miss_asid) && $stable(miss_vpn))); // R3
   AST_REFILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_pend && rf_valid) |=> !miss_pend); // R5
   AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R5
   AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_valid && !fl_cmd[31] && fl_cmd[1:0] == 2'b00) |=> (valid_vec == '0)); // R6
endmodule

bind tlbx_core tlbx_chk #(.N(N)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .lk_valid(lk_valid), .lk_ready(lk_ready),
   .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit),
   .miss_pend(miss_pend), .miss_asid(miss_asid), .miss_vpn(miss_vpn),
   .rf_valid(rf_valid), .fl_valid(fl_valid), .fl_cmd(fl_cmd),
   .cfg_hum(cfg_hum_q), .hit_vec(hit_vec), .valid_vec(valid_vec)
);

// File: tb/tb_tlbx_core.sv
module tb_tlbx_core;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;
   localparam int PFN_W = 20;
   localparam int NVEC = 8;
   // {asid, va, expect_hit, expect_pfn}
   localparam logic [59:0] VEC [NVEC] = '{
      {7'd5, 32'h1234_5678, 1'b1, 20'hABCDE},
      {7'd9, 32'h1234_5000, 1'b1, 20'h22222},
      {7'd7, 32'h1234_5000, 1'b0, 20'h00000},
      {7'd5, 32'h1234_6FFF, 1'b1, 20'h11111},
      {7'd5, 32'h1234_7000, 1'b0, 20'h00000},
      {7'd9, 32'h4000_4123, 1'b1, 20'h44444},
      {7'd5, 32'h4000_5000, 1'b1, 20'h55555},
      {7'd5, 32'h4000_0000, 1'b1, 20'h33333}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic lk_valid = 1'b0;
   logic lk_ready;
   logic [6:0] lk_asid = '0;
   logic [31:0] lk_va = '0;
   logic lk_rsp_valid, lk_hit;
   logic [PFN_W-1:0] lk_pfn;
   logic [2:0] lk_perm;
   logic miss_pend;
   logic [6:0] miss_asid;
   logic [19:0] miss_vpn;
   logic rf_valid = 1'b0;
   logic [6:0] rf_asid = '0;
   logic [19:0] rf_vpn = '0;
   logic [PFN_W-1:0] rf_pfn = '0;
   logic [2:0] rf_perm = '0;
   logic fl_valid = 1'b0;
   logic [31:0] fl_cmd = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tlbx_core #(.N(N), .PFN_W(PFN_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_asid(lk_asid), .lk_va(lk_va),
      .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
      .miss_pend(miss_pend), .miss_asid(miss_asid), .miss_vpn(miss_vpn),
      .rf_valid(rf_valid), .rf_asid(rf_asid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_perm(rf_perm),
      .fl_valid(fl_valid), .fl_cmd(fl_cmd)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_cfg(logic [31:0] w);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic refill(logic [6:0] a, logic [19:0] v, logic [19:0] p, logic [2:0] pm);
      @(negedge clk); rf_valid = 1'b1; rf_asid = a; rf_vpn = v; rf_pfn = p; rf_perm = pm;
      @(negedge clk); rf_valid = 1'b0;
   endtask

   task automatic flush(logic [31:0] c);
      @(negedge clk); fl_valid = 1'b1; fl_cmd = c;
      @(negedge clk); fl_valid = 1'b0;
   endtask

   task automatic flush_refill(logic [31:0] c, logic [6:0] a, logic [19:0] v, logic [19:0] p);
      @(negedge clk);
      fl_valid = 1'b1; fl_cmd = c;
      rf_valid = 1'b1; rf_asid = a; rf_vpn = v; rf_pfn = p; rf_perm = 3'b100;
      @(negedge clk); fl_valid = 1'b0; rf_valid = 1'b0;
   endtask

   // issue one lookup; answer sampled at the negedge after the accepting edge
   task automatic look(string req, logic [6:0] a, logic [31:0] va, logic eh, logic [19:0] ep);
      @(negedge clk); lk_valid = 1'b1; lk_asid = a; lk_va = va;
      @(negedge clk); lk_valid = 1'b0;
      chk(req, {31'd0, lk_rsp_valid}, 32'd1);
      chk(req, {31'd0, lk_hit}, {31'd0, eh});
      if (eh) chk(req, {12'd0, lk_pfn}, {12'd0, ep});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rsp", {31'd0, lk_rsp_valid}, 32'd0);
      chk("R1 pend", {31'd0, miss_pend}, 32'd0);
      chk("R1 ready", {31'd0, lk_ready}, 32'd1);

      // R3 first miss captured; R4 blocking with hit-under-miss off
      look("R3 miss", 7'd5, 32'h1234_5000, 1'b0, 20'h0);
      chk("R3 pend", {31'd0, miss_pend}, 32'd1);
      chk("R3 asid", {25'd0, miss_asid}, 32'd5);
      chk("R3 vpn", {12'd0, miss_vpn}, 32'h12345);
      chk("R4 blocked", {31'd0, lk_ready}, 32'd0);

      // R5 refill releases the miss
      refill(7'd5, 20'h12345, 20'hABCDE, 3'b101);
      chk("R5 pend clr", {31'd0, miss_pend}, 32'd0);
      chk("R5 ready", {31'd0, lk_ready}, 32'd1);
      // R8 these fill lines 1..5 in order (first invalid)
      refill(7'd5, 20'h12346, 20'h11111, 3'b100);
      refill(7'd9, 20'h12345, 20'h22222, 3'b110);
      refill(7'd5, 20'h40000, 20'h33333, 3'b100);
      refill(7'd9, 20'h40004, 20'h44444, 3'b100);
      refill(7'd5, 20'h40005, 20'h55555, 3'b100);

      set_cfg(32'h2000_0000); // R4 hit-under-miss on, all lines
      for (int i = 0; i < NVEC; i++) begin
         look("R2 table", VEC[i][59:53], VEC[i][52:21], VEC[i][20], VEC[i][19:0]);
      end
      // R4 captured miss unchanged by the later miss
      chk("R4 pend", {31'd0, miss_pend}, 32'd1);
      chk("R4 asid held", {25'd0, miss_asid}, 32'd7);
      chk("R4 vpn held", {12'd0, miss_vpn}, 32'h12345);
      chk("R4 ready", {31'd0, lk_ready}, 32'd1);
      look("R2 perm", 7'd5, 32'h1234_5000, 1'b1, 20'hABCDE);
      chk("R2 perm val", {29'd0, lk_perm}, 32'd5);

      refill(7'd7, 20'h12345, 20'h77777, 3'b110);
      chk("R5 pend clr2", {31'd0, miss_pend}, 32'd0);
      look("R5 new line", 7'd7, 32'h1234_5000, 1'b1, 20'h77777);

      // R6 group flush, tag 9
      flush(32'h8904_0007);
      look("R6 grp gone", 7'd9, 32'h4000_4000, 1'b0, 20'h0);
      look("R6 grp other tag", 7'd5, 32'h4000_5000, 1'b1, 20'h55555);
      // R6 section flush, tag 5
      flush(32'h8504_0002);
      look("R6 sect a", 7'd5, 32'h4000_0000, 1'b0, 20'h0);
      look("R6 sect b", 7'd5, 32'h4000_5000, 1'b0, 20'h0);
      look("R6 sect keep", 7'd5, 32'h1234_5000, 1'b1, 20'hABCDE);
      // R6 whole address space 9
      flush(32'h8900_0000);
      look("R6 tag gone", 7'd9, 32'h1234_5000, 1'b0, 20'h0);
      look("R6 tag keep5", 7'd5, 32'h1234_5000, 1'b1, 20'hABCDE);
      look("R6 tag keep7", 7'd7, 32'h1234_5000, 1'b1, 20'h77777);
      // R6 kind 1 removes nothing
      flush(32'h0000_0001);
      look("R6 kind1", 7'd5, 32'h1234_5000, 1'b1, 20'hABCDE);

      // R7 flush and refill together
      flush_refill(32'h8504_0002, 7'd5, 20'h40010, 20'h61616);
      look("R7 dropped", 7'd5, 32'h4001_0000, 1'b0, 20'h0);
      flush_refill(32'h8504_0002, 7'd9, 20'h50000, 20'h62626);
      look("R7 kept", 7'd9, 32'h5000_0000, 1'b1, 20'h62626);

      // R6 flush everything
      flush(32'h0000_0000);
      look("R6 all a", 7'd5, 32'h1234_5000, 1'b0, 20'h0);
      look("R6 all b", 7'd7, 32'h1234_5000, 1'b0, 20'h0);
      look("R6 all c", 7'd9, 32'h5000_0000, 1'b0, 20'h0);

      // R9 round-robin over 2 lines
      set_cfg(32'h3000_0002);
      refill(7'd1, 20'h00001, 20'hA0001, 3'b100);
      refill(7'd1, 20'h00002, 20'hB0002, 3'b100);
      refill(7'd1, 20'h00003, 20'hC0003, 3'b100);
      look("R9 evicted", 7'd1, 32'h0000_1000, 1'b0, 20'h0);
      look("R9 kept", 7'd1, 32'h0000_2000, 1'b1, 20'hB0002);
      look("R9 newest", 7'd1, 32'h0000_3000, 1'b1, 20'hC0003);

      // R8 full, no round-robin: line 0 replaced
      set_cfg(32'h2000_0002);
      refill(7'd1, 20'h00004, 20'hD0004, 3'b100);
      look("R8 line0 out", 7'd1, 32'h0000_3000, 1'b0, 20'h0);
      look("R8 line1 kept", 7'd1, 32'h0000_2000, 1'b1, 20'hB0002);
      look("R8 new", 7'd1, 32'h0000_4000, 1'b1, 20'hD0004);

      // R5 update in place
      refill(7'd1, 20'h00002, 20'h99999, 3'b011);
      look("R5 in place", 7'd1, 32'h0000_2000, 1'b1, 20'h99999);
      look("R5 other kept", 7'd1, 32'h0000_4000, 1'b1, 20'hD0004);

      // R10 only line 0 in use
      set_cfg(32'h2000_0001);
      look("R10 hidden", 7'd1, 32'h0000_2000, 1'b0, 20'h0);
      look("R10 line0", 7'd1, 32'h0000_4000, 1'b1, 20'hD0004);
      refill(7'd2, 20'h00005, 20'h55005, 3'b100);
      set_cfg(32'h2000_0000);
      look("R10 alloc line0", 7'd1, 32'h0000_4000, 1'b0, 20'h0);
      look("R10 new", 7'd2, 32'h0000_5000, 1'b1, 20'h55005);
      look("R10 contents kept", 7'd1, 32'h0000_2000, 1'b1, 20'h99999);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule